// File: doc/BRIEF.md
# Nonvolatile Store Busy Sequencer

This block sits behind the serial command decoder of a digitally controlled potentiometer and models the slow commit of a data-register store into nonvolatile cells. The decoder hands over a store request once it has seen a full write frame. The request carries a register index and either a host-supplied byte or the current wiper position. The sequencer holds the request as pending and commits it only when chip select returns high to close the frame.

A committed store raises a write-in-progress flag for a fixed number of system clock cycles, set by a parameter. The default models a 10 ms worst case at 125 MHz. The register array takes the new byte only at the end of that window, so reads made during the window return the old contents. The active-low write-protect input is sampled at the commit instant, and a low level there cancels the store. Requests that cannot be taken produce a one-cycle reject pulse and leave both the pending slot and the array untouched. This covers requests made while a store runs, outside a frame, or as a wiper transfer to a register outside bank 0.

Top module: `nvw_store_seq`

## Requirements
- R1: After synchronous reset, `busy` and `reject` are 0 and all 16 registers read 0.
- R2: An accepted request changes nothing while `cs_n` stays low: `busy` stays 0 and the target register keeps its value until the frame closes.
- R3: When `cs_n` is sampled high after being sampled low, and a request is pending with `wp_n` high, `busy` goes to 1 on the next cycle and stays 1 for exactly STORE_CYCLES cycles.
- R4: During the busy window `rd_data` returns the old register contents. The new value is readable from the first cycle in which `busy` is 0 again.
- R5: If `wp_n` is 0 in the cycle in which the frame closes, the pending store is discarded: `busy` stays 0 and the register is unchanged.
- R6: `wp_n` is relevant only in the closing cycle. A low level earlier in the frame, or after the commit, neither blocks nor aborts the store.
- R7: A request (`req_valid`=1) made while `busy`=1 or while `cs_n`=1 gives `reject`=1 on the next cycle for one cycle. It is not held and does not alter any register.
- R8: With `req_src`=1 (wiper transfer), the stored byte is `wiper_pos` as sampled in the request cycle. With `req_src`=0 it is `req_data`.
- R9: A wiper transfer (`req_src`=1) whose index is 4 or more (outside bank 0, indices 0 to 3) is rejected as in R7, and no store follows.
- R10: A frame that closes with no request pending, including one whose request was discarded by write protect, starts no store.
- R11: Of several accepted requests within one frame, only the last one is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, low during a frame |
| wp_n | input | 1 | Write protect, low blocks stores |
| req_valid | input | 1 | One-cycle store request from the decoder |
| req_src | input | 1 | 0: host byte, 1: wiper transfer |
| req_idx | input | 4 | Target register index (bank in bits 3:2) |
| req_data | input | 8 | Host byte for a direct write |
| wiper_pos | input | 8 | Current wiper position |
| rd_idx | input | 4 | Register read index |
| rd_data | output | 8 | Register read data |
| busy | output | 1 | Write in progress |
| reject | output | 1 | One-cycle pulse for a refused request |

## Verification
The hardest situation to reach is one where the write-protect level differs between the request cycle and the frame-closing cycle, or where a second frame opens and issues a request while an earlier store is still counting down. The stimulus reaches these by driving `wp_n` and `cs_n` on chosen falling clock edges between request pulses. It opens a new frame in the middle of the busy window, and it shortens STORE_CYCLES to 12 so that the window can be measured end to end. A behavioural model tracks pending state, the remaining busy cycles and the register contents, and it is compared with `busy`, `reject` and `rd_data` after every clock.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
    localparam int DATA_W    = 8;
    localparam int NUM_REGS  = 16;
    localparam int BANK_REGS = 4;
    localparam int IDX_W     = $clog2(NUM_REGS);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic {
        SRC_HOST  = 1'b0,
        SRC_WIPER = 1'b1
    } store_src_e;

    typedef struct packed {
        idx_t  idx;
        word_t data;
    } store_t;

    // Wiper transfers may only target the first bank.
    function automatic logic target_ok(store_src_e src, idx_t idx);
        return (src == SRC_HOST) || (int'(idx) < BANK_REGS);
    endfunction

    function automatic word_t pick_data(store_src_e src, word_t host, word_t wiper);
        return (src == SRC_WIPER) ? wiper : host;
    endfunction
endpackage

// File: rtl/nvw_frame_gate.sv
module nvw_frame_gate
    import nvw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       wp_n,
    input  logic       busy,
    input  logic       req_valid,
    input  store_src_e req_src,
    input  idx_t       req_idx,
    input  word_t      req_data,
    input  word_t      wiper_pos,
    output logic       commit,
    output store_t     commit_req,
    output logic       reject
);
    logic   cs_q;
    logic   pend_v;
    store_t pend;
    logic   frame_close;
    logic   accept;

    assign frame_close = cs_n & ~cs_q;
    assign accept      = req_valid & ~cs_n & ~busy & target_ok(req_src, req_idx);
    assign commit      = frame_close & pend_v & wp_n;
    assign commit_req  = pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= 1'b1;
            pend_v <= 1'b0;
            pend   <= '0;
            reject <= 1'b0;
        end else begin
            cs_q   <= cs_n;
            reject <= req_valid & ~accept;
            if (frame_close) begin
                pend_v <= 1'b0;
            end else if (accept) begin
                pend_v <= 1'b1;
                pend   <= '{idx: req_idx, data: pick_data(req_src, req_data, wiper_pos)};
            end
        end
    end
endmodule

// File: rtl/nvw_busy_timer.sv
module nvw_busy_timer
    import nvw_pkg::*;
#(
    parameter int STORE_CYCLES = 1250000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   commit,
    input  store_t commit_req,
    output logic   busy,
    output logic   wr_en,
    output store_t wr_req
);
    localparam int CNT_W = (STORE_CYCLES > 1) ? $clog2(STORE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(STORE_CYCLES - 1);

    logic [CNT_W-1:0] remain;
    store_t           held;

    assign wr_en  = busy & (remain == '0);
    assign wr_req = held;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
            held   <= '0;
        end else if (commit && !busy) begin
            busy   <= 1'b1;
            remain <= LOAD;
            held   <= commit_req;
        end else if (busy) begin
            if (remain == '0) begin
                busy <= 1'b0;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end
endmodule

// File: rtl/nvw_reg_bank.sv
module nvw_reg_bank
    import nvw_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  store_t wr_req,
    input  idx_t   rd_idx,
    output word_t  rd_data
);
    word_t cells [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
        word_t cell_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q <= '0;
            end else if (wr_en && (wr_req.idx == idx_t'(g))) begin
                cell_q <= wr_req.data;
            end
        end
        assign cells[g] = cell_q;
    end

    always_comb begin
        rd_data = cells[rd_idx];
    end
endmodule

// File: rtl/nvw_store_seq.sv
module nvw_store_seq
    import nvw_pkg::*;
#(
    parameter int STORE_CYCLES = 1250000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wp_n,
    input  logic              req_valid,
    input  logic              req_src,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [DATA_W-1:0] req_data,
    input  logic [DATA_W-1:0] wiper_pos,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              reject
);
    logic   commit;
    store_t commit_req;
    logic   store_wr;
    store_t store_req;
    logic   busy_q;

    nvw_frame_gate i_gate (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .wp_n       (wp_n),
        .busy       (busy_q),
        .req_valid  (req_valid),
        .req_src    (store_src_e'(req_src)),
        .req_idx    (req_idx),
        .req_data   (req_data),
        .wiper_pos  (wiper_pos),
        .commit     (commit),
        .commit_req (commit_req),
        .reject     (reject)
    );

    nvw_busy_timer #(.STORE_CYCLES(STORE_CYCLES)) i_timer (
        .clk        (clk),
        .rst        (rst),
        .commit     (commit),
        .commit_req (commit_req),
        .busy       (busy_q),
        .wr_en      (store_wr),
        .wr_req     (store_req)
    );

    nvw_reg_bank i_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (store_wr),
        .wr_req  (store_req),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    assign busy = busy_q;
endmodule

// File: rtl/nvw_store_seq_chk.sv
module nvw_store_seq_chk #(
    parameter int STORE_CYCLES = 1250000
) (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       wp_n,
    input logic       req_valid,
    input logic       req_src,
    input logic [3:0] req_idx,
    input logic       busy,
    input logic       reject,
    input logic       wr_en
);
    logic [31:0] blen;

    always_ff @(posedge clk) begin
        if (rst)       blen <= '0;
        else if (busy) blen <= blen + 1'b1;
        else           blen <= '0;
    end

    a_r3_busy_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (blen == 32'(STORE_CYCLES)));

    a_r3_no_overrun: assert property (@(posedge clk) disable iff (rst)
        busy |-> (blen < 32'(STORE_CYCLES)));

    a_r2_start_at_close: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cs_n));

    a_r5_start_needs_wp: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wp_n));

    a_r7_reject_busy: assert property (@(posedge clk) disable iff (rst)
        (req_valid && busy) |=> reject);

    a_r7_reject_outside: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cs_n) |=> reject);

    a_r9_bad_transfer: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_src && (req_idx >= 4'd4)) |=> reject);

    a_r4_write_in_window: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy);

    a_r4_write_ends_window: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !busy);
endmodule

bind nvw_store_seq nvw_store_seq_chk #(.STORE_CYCLES(STORE_CYCLES)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .wp_n      (wp_n),
    .req_valid (req_valid),
    .req_src   (req_src),
    .req_idx   (req_idx),
    .busy      (busy),
    .reject    (reject),
    .wr_en     (store_wr)
);

// File: tb/test_nvw_store_seq.sv
module test_nvw_store_seq;
    localparam int SC = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       wp_n = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_src = 1'b0;
    logic [3:0] req_idx = '0;
    logic [7:0] req_data = '0;
    logic [7:0] wiper_pos = '0;
    logic [3:0] rd_idx = '0;
    logic [7:0] rd_data;
    logic       busy;
    logic       reject;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";
    bit done = 0;

    always #4 clk = ~clk;

    nvw_store_seq #(.STORE_CYCLES(SC)) i_nvw_store_seq (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wp_n(wp_n),
        .req_valid(req_valid), .req_src(req_src), .req_idx(req_idx),
        .req_data(req_data), .wiper_pos(wiper_pos), .rd_idx(rd_idx),
        .rd_data(rd_data), .busy(busy), .reject(reject)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_regs [16];
    bit m_busy, m_pend, m_csq, m_rej;
    int m_left, m_pidx, m_pdata, m_cidx, m_cdata;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_regs[i]) m_regs[i] = 0;
            m_busy = 0; m_pend = 0; m_csq = 1; m_rej = 0; m_left = 0;
        end else begin
            bit closing, was_busy, nrej;
            closing  = cs_n && !m_csq;
            was_busy = m_busy;
            nrej     = 0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_regs[m_cidx] = m_cdata;
                    m_busy = 0;
                end
            end
            if (closing) begin
                if (m_pend && wp_n) begin
                    m_busy = 1; m_left = SC; m_cidx = m_pidx; m_cdata = m_pdata;
                end
                m_pend = 0;
            end
            if (req_valid) begin
                if (was_busy || cs_n || (req_src && req_idx >= 4)) nrej = 1;
                else begin
                    m_pend = 1; m_pidx = int'(req_idx);
                    m_pdata = req_src ? int'(wiper_pos) : int'(req_data);
                end
            end
            m_rej = nrej;
            m_csq = cs_n;
        end
        #2;
        if (!rst && !done) begin
            chk({cur_tag, " busy"}, int'(busy), int'(m_busy));
            chk({cur_tag, " reject"}, int'(reject), int'(m_rej));
            chk({cur_tag, " rd_data"}, int'(rd_data), m_regs[rd_idx]);
        end
    end

    task automatic read_reg(input int idx, output int val);
        rd_idx = 4'(idx);
        #1;
        val = int'(rd_data);
    endtask

    task automatic open_frame();
        @(negedge clk); cs_n = 1'b0;
    endtask

    task automatic close_frame();
        @(negedge clk); cs_n = 1'b1;
    endtask

    task automatic send_req(input bit src, input int idx, input int data, output int rej);
        @(negedge clk);
        req_valid = 1'b1; req_src = src; req_idx = 4'(idx); req_data = 8'(data);
        @(negedge clk);
        req_valid = 1'b0;
        rej = int'(reject);
    endtask

    task automatic measure_busy(output int n);
        n = 0;
        while (busy === 1'b1 && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        int n;
        @(negedge clk);
        measure_busy(n);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v, rj, n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        cur_tag = "R1";
        chk("R1 busy", int'(busy), 0);
        chk("R1 reject", int'(reject), 0);
        for (int i = 0; i < 16; i++) begin
            read_reg(i, v);
            chk("R1 reg", v, 0);
        end

        // R2, R3, R4 direct write deferred to frame close
        cur_tag = "R2";
        open_frame();
        send_req(0, 5, 'hA5, rj);
        chk("R2 accepted", rj, 0);
        rd_idx = 4'd5;
        repeat (4) begin
            @(negedge clk);
            chk("R2 busy in frame", int'(busy), 0);
            read_reg(5, v);
            chk("R2 reg in frame", v, 0);
        end
        cur_tag = "R3";
        close_frame();
        @(negedge clk);
        read_reg(5, v);
        chk("R4 old value while busy", v, 0);
        measure_busy(n);
        chk("R3 busy length", n, SC);
        read_reg(5, v);
        chk("R4 new value after busy", v, 'hA5);

        // R5 write protect at close
        cur_tag = "R5";
        wp_n = 1'b0;
        open_frame();
        send_req(0, 9, 'h5A, rj);
        close_frame();
        @(negedge clk);
        chk("R5 no busy under protect", int'(busy), 0);
        repeat (15) @(negedge clk);
        read_reg(9, v);
        chk("R5 reg unchanged", v, 0);

        // R10 empty frame after discarded request
        cur_tag = "R10";
        @(negedge clk); wp_n = 1'b1;
        open_frame();
        close_frame();
        @(negedge clk);
        chk("R10 no store on empty frame", int'(busy), 0);

        // R6 protect only sampled at close
        cur_tag = "R6";
        @(negedge clk); wp_n = 1'b0;
        open_frame();
        send_req(0, 10, 'h3C, rj);
        @(negedge clk); wp_n = 1'b1;
        close_frame();
        @(negedge clk);
        chk("R6 store despite early protect", int'(busy), 1);
        wp_n = 1'b0;
        measure_busy(n);
        chk("R6 late protect no abort", n, SC);
        read_reg(10, v);
        chk("R6 reg stored", v, 'h3C);
        wp_n = 1'b1;

        // R7 request during busy and outside frame
        cur_tag = "R7";
        open_frame();
        send_req(0, 11, 'h11, rj);
        close_frame();
        @(negedge clk);
        chk("R7 store running", int'(busy), 1);
        open_frame();
        send_req(0, 3, 'hEE, rj);
        chk("R7 reject while busy", rj, 1);
        @(negedge clk);
        chk("R7 reject single cycle", int'(reject), 0);
        close_frame();
        wait_idle();
        repeat (2) @(negedge clk);
        chk("R7 no second store", int'(busy), 0);
        read_reg(3, v);
        chk("R7 rejected reg untouched", v, 0);
        read_reg(11, v);
        chk("R7 first store done", v, 'h11);
        send_req(0, 4, 'h44, rj);
        chk("R7 reject outside frame", rj, 1);
        open_frame();
        close_frame();
        @(negedge clk);
        chk("R7 outside request not held", int'(busy), 0);

        // R8 wiper transfer
        cur_tag = "R8";
        wiper_pos = 8'h6B;
        open_frame();
        send_req(1, 2, 'h00, rj);
        chk("R8 transfer accepted", rj, 0);
        wiper_pos = 8'h00;
        close_frame();
        wait_idle();
        read_reg(2, v);
        chk("R8 wiper value stored", v, 'h6B);

        // R9 transfer outside first bank
        cur_tag = "R9";
        wiper_pos = 8'h77;
        open_frame();
        send_req(1, 6, 'h00, rj);
        chk("R9 bad transfer rejected", rj, 1);
        close_frame();
        @(negedge clk);
        chk("R9 no store", int'(busy), 0);
        read_reg(6, v);
        chk("R9 reg untouched", v, 0);

        // R11 last request in frame wins
        cur_tag = "R11";
        open_frame();
        send_req(0, 7, 'h77, rj);
        send_req(0, 8, 'h88, rj);
        close_frame();
        wait_idle();
        read_reg(7, v);
        chk("R11 earlier request dropped", v, 0);
        read_reg(8, v);
        chk("R11 last request stored", v, 'h88);

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule